// File: doc/BRIEF.md
# Glitch-Free Reprogrammable Clock Divider Bank

This block derives six divided outputs from one source clock. Each output has its own divide value. Each output also runs as a registered square-wave level, or as a clock enable when its divide value is 1. Software changes a divide value only through a stop-and-confirm handshake. It sets the output's hold bit, then waits until the output has finished its current period and parked low, which is reported by an acknowledge bit. It then loads the new value and clears the hold bit. The output restarts with a fresh, full-length period, so no shortened pulse ever appears.

Access is through a simple single-cycle register port. The port has one address, a write strobe, 32-bit write data and a registered 32-bit read result. There are two resets. A cold reset returns everything to its initial state. A warm reset only restarts the divider counters and keeps the control and divide-value registers.

Top module: `clkdiv_bank`

## Requirements
- R1: With divide value N (N ≥ 2), output i repeats with a period of N source cycles. It is high for the first (N+1)/2 cycles of each period and low for the rest. With N = 1 it stays high every cycle.
- R2: Setting hold bit i (bits 5:0 of the control register at address 0) lets output i finish its current period. The output then stays low for as long as the bit is set. The other outputs are unaffected.
- R3: Acknowledge bit i (bits 5:0 of the read-only status register at address 1) is 1 only while output i is parked low under hold. It reads 0 again one cycle after the hold bit is cleared.
- R4: A write to divide register i (address 2+i, bits 7:0) takes effect only when acknowledge bit i is 1 and the value is non-zero. Otherwise the stored value stays unchanged.
- R5: The hold-all bit (control bit 6) parks and acknowledges all six outputs, as if every hold bit were set.
- R6: A cold reset clears all hold bits, hold-all and the enable bit (control bit 8). It sets every divide value to 2, drives all outputs and acknowledge bits to 0, and makes control bit 9 read as 1.
- R7: A warm reset leaves the control bits and divide values unchanged. It restarts every divider, so a held output parks again and re-acknowledges, and the others resume running.
- R8: Control bit 9 (regulator select) always reads as the complement of the enable bit 8. It changes in the same write as bit 8, and the written value of bit 9 is ignored.
- R9: Read data is registered and appears one cycle after the address. Unused bits and unused addresses read 0, and writes to the status register have no effect.
- R10: After the write that clears a hold bit, the output stays low for two more edges. It rises on the second edge after the write and begins a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| cold_rst | input | 1 | Synchronous full reset, active high |
| warm_rst | input | 1 | Synchronous divider-only reset, active high |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 4 | Register address for both read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the previous cycle's address |
| clk_out | output | 6 | Divided outputs, one per divider |

## Verification
The hardest situation to reach is the one just around a reprogramming. An output must park only at a period boundary, the acknowledge bit must rise and fall around it, and the new period must start on an exact edge. Random divide values from 1 to 12 land on random outputs, each reprogrammed through the full handshake. The output is then traced sample by sample from the release write, with the status read in the same cycles. Held outputs across a warm reset are set up on purpose, and so are writes attempted without an acknowledge and writes of zero.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_ACK  = 1;
  localparam int unsigned ADDR_DIV0 = 2;
  localparam int unsigned REG_W     = 32;
endpackage

// File: rtl/clkdiv_unit.sv
module clkdiv_unit #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             ack
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] hi_len;
  logic             parked_q;
  logic             at_end;

  // high phase is the rounded-up half of the period
  assign hi_len = (div >> 1) + {{(DIV_W-1){1'b0}}, div[0]};
  assign at_end = (cnt_q >= div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      parked_q <= 1'b0;
      tick     <= 1'b0;
      ack      <= 1'b0;
    end else if (parked_q) begin
      tick     <= 1'b0;
      ack      <= hold;
      parked_q <= hold;
      cnt_q    <= '0;
    end else begin
      tick <= (cnt_q < hi_len);
      ack  <= 1'b0;
      if (at_end) begin
        cnt_q    <= '0;
        parked_q <= hold;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int N_OUT    = 6,
  parameter int DIV_W    = 8,
  parameter int ADDR_W   = 4,
  parameter int DIV_INIT = 2
) (
  input  logic                   clk,
  input  logic                   cold_rst,
  input  logic                   warm_rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [REG_W-1:0]       wr_data,
  input  logic [N_OUT-1:0]       ack,
  output logic [N_OUT-1:0]       hold_q,
  output logic                   hold_all_q,
  output logic                   en_q,
  output logic [N_OUT-1:0]       hold_eff,
  output logic [N_OUT*DIV_W-1:0] div_flat,
  output logic [REG_W-1:0]       rd_data
);
  localparam int BIT_ALL = N_OUT;
  localparam int BIT_EN  = N_OUT + 2;
  localparam int BIT_SEL = N_OUT + 3;

  logic [DIV_W-1:0] div_q [N_OUT];
  logic [REG_W-1:0] rd_next;
  logic             wr_ok;

  assign wr_ok    = wr_en && !warm_rst;
  assign hold_eff = hold_q | {N_OUT{hold_all_q}};

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      hold_q     <= '0;
      hold_all_q <= 1'b0;
      en_q       <= 1'b0;
    end else if (wr_ok && addr == ADDR_W'(ADDR_CTRL)) begin
      hold_q     <= wr_data[N_OUT-1:0];
      hold_all_q <= wr_data[BIT_ALL];
      en_q       <= wr_data[BIT_EN];
    end
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_div
    always_ff @(posedge clk) begin
      if (cold_rst)
        div_q[i] <= DIV_W'(DIV_INIT);
      else if (wr_ok && addr == ADDR_W'(ADDR_DIV0 + i) && ack[i] &&
               wr_data[DIV_W-1:0] != '0)
        div_q[i] <= wr_data[DIV_W-1:0];
    end
    assign div_flat[i*DIV_W +: DIV_W] = div_q[i];
  end

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(ADDR_CTRL)) begin
      rd_next[N_OUT-1:0] = hold_q;
      rd_next[BIT_ALL]   = hold_all_q;
      rd_next[BIT_EN]    = en_q;
      rd_next[BIT_SEL]   = ~en_q;
    end else if (addr == ADDR_W'(ADDR_ACK)) begin
      rd_next[N_OUT-1:0] = ack;
    end
    for (int k = 0; k < N_OUT; k++) begin
      if (addr == ADDR_W'(ADDR_DIV0 + k))
        rd_next[DIV_W-1:0] = div_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (cold_rst || warm_rst)
      rd_data <= '0;
    else
      rd_data <= rd_next;
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int N_OUT    = 6,
  parameter int DIV_W    = 8,
  parameter int ADDR_W   = 4,
  parameter int DIV_INIT = 2
) (
  input  logic              clk,
  input  logic              cold_rst,
  input  logic              warm_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic [N_OUT-1:0]  clk_out
);
  logic [N_OUT-1:0]       ack;
  logic [N_OUT-1:0]       hold_q;
  logic                   hold_all_q;
  logic                   en_q;
  logic [N_OUT-1:0]       hold_eff;
  logic [N_OUT*DIV_W-1:0] div_flat;
  logic                   div_rst;

  assign div_rst = cold_rst | warm_rst;

  clkdiv_regs #(
    .N_OUT(N_OUT), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DIV_INIT(DIV_INIT)
  ) u_regs (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .ack(ack),
    .hold_q(hold_q), .hold_all_q(hold_all_q), .en_q(en_q),
    .hold_eff(hold_eff), .div_flat(div_flat), .rd_data(rd_data)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_unit
    clkdiv_unit #(.DIV_W(DIV_W)) u_unit (
      .clk(clk), .rst(div_rst), .hold(hold_eff[i]),
      .div(div_flat[i*DIV_W +: DIV_W]),
      .tick(clk_out[i]), .ack(ack[i])
    );
  end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int N_OUT = 6,
  parameter int DIV_W = 8
) (
  input logic                   clk,
  input logic                   cold_rst,
  input logic                   warm_rst,
  input logic [N_OUT-1:0]       clk_out,
  input logic [N_OUT-1:0]       ack,
  input logic [N_OUT-1:0]       hold_eff,
  input logic [N_OUT-1:0]       hold_q,
  input logic                   hold_all_q,
  input logic                   en_q,
  input logic [N_OUT*DIV_W-1:0] div_flat
);
  // R3
  ack_quiet_chk: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    ((ack & clk_out) == '0));

  // R3
  ack_needs_hold_chk: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    ((ack & ~$past(hold_eff)) == '0));

  // R7
  warm_keep_chk: assert property (@(posedge clk) disable iff (cold_rst)
    warm_rst |=> $stable({hold_q, hold_all_q, en_q, div_flat}));

  for (genvar i = 0; i < N_OUT; i++) begin : g_chk
    // R4
    div_guard_chk: assert property (@(posedge clk) disable iff (cold_rst)
      (div_flat[i*DIV_W +: DIV_W] != $past(div_flat[i*DIV_W +: DIV_W])) |-> $past(ack[i]));
  end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.N_OUT(N_OUT), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst), .clk_out(clk_out),
  .ack(ack), .hold_eff(hold_eff), .hold_q(hold_q), .hold_all_q(hold_all_q),
  .en_q(en_q), .div_flat(div_flat)
);

// File: tb/clkdiv_bank_test.sv
module clkdiv_bank_test;
  localparam int NO = 6;

  logic        clk = 1'b0;
  logic        cold_rst = 1'b1;
  logic        warm_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [NO-1:0] clk_out;

  int errs = 0;
  int checks = 0;
  logic [31:0] ctrl_sh = '0;
  int div_sh [NO];

  always #2 clk = ~clk;

  clkdiv_bank uut (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .clk_out(clk_out)
  );

  function automatic logic [31:0] exp_ctrl(logic [31:0] c);
    logic [31:0] v;
    v = c & 32'h0000_017F;
    v[9] = ~c[8];
    return v;
  endfunction

  function automatic logic exp_level(int k, int n);
    return (k % n) < ((n + 1) / 2);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_ack(int i, string req);
    logic [31:0] d;
    bit got = 0;
    for (int t = 0; t < 200; t++) begin
      rd(4'd1, d);
      if (d[i]) begin got = 1; break; end
    end
    chk(req, {31'd0, got}, 32'd1);
    chk(req, {31'd0, clk_out[i]}, 32'd0);
  endtask

  // R1 trace a free-running output from its next rising edge
  task automatic trace_free(int i, int n, string req);
    int bad = 0;
    if (n == 1) begin
      for (int k = 0; k < 4; k++) begin
        if (clk_out[i] !== 1'b1) bad++;
        @(negedge clk);
      end
    end else begin
      for (int t = 0; t < 40 && clk_out[i] !== 1'b0; t++) @(negedge clk);
      for (int t = 0; t < 40 && clk_out[i] !== 1'b1; t++) @(negedge clk);
      for (int k = 0; k < 2 * n; k++) begin
        if (clk_out[i] !== exp_level(k, n)) bad++;
        @(negedge clk);
      end
    end
    chk(req, bad, 0);
  endtask

  // full handshake: hold, wait ack, load, release, trace
  task automatic prog(int i, int n);
    logic [31:0] d;
    int bad = 0;
    ctrl_sh[i] = 1'b1;
    wr(4'd0, ctrl_sh);
    wait_ack(i, "R2");
    wr(4'(2 + i), 32'(n));
    div_sh[i] = n;
    rd(4'(2 + i), d);
    chk("R4", d, 32'(n));
    ctrl_sh[i] = 1'b0;
    wr(4'd0, ctrl_sh);
    chk("R10", {31'd0, clk_out[i]}, 32'd0);
    rd(4'd1, d);
    chk("R3", {31'd0, d[i]}, 32'd1);
    chk("R10", {31'd0, clk_out[i]}, 32'd0);
    rd(4'd1, d);
    chk("R3", {31'd0, d[i]}, 32'd0);
    for (int k = 0; k < 2 * n + 2; k++) begin
      if (clk_out[i] !== exp_level(k, n)) bad++;
      @(negedge clk);
    end
    chk("R1", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < NO; i++) div_sh[i] = 2;
    repeat (3) @(negedge clk);
    chk("R6", {26'd0, clk_out}, 32'd0);
    cold_rst = 1'b0;

    // R6 cold reset state
    rd(4'd0, d); chk("R6", d, 32'h200);
    rd(4'd1, d); chk("R6", d, 32'h0);
    for (int i = 0; i < NO; i++) begin
      rd(4'(2 + i), d); chk("R6", d, 32'd2);
    end
    trace_free(0, 2, "R1");

    // R8 select bit follows enable complement
    wr(4'd0, 32'h300); rd(4'd0, d); chk("R8", d, 32'h100);
    wr(4'd0, 32'h000); rd(4'd0, d); chk("R8", d, 32'h200);

    // R9 status not writable, unused address zero
    wr(4'd1, 32'h3F); rd(4'd1, d); chk("R9", d, 32'h0);
    rd(4'd15, d); chk("R9", d, 32'h0);

    // R4 write without acknowledge ignored
    wr(4'd4, 32'd9); rd(4'd4, d); chk("R4", d, 32'd2);

    // directed corners
    prog(1, 1);
    prog(2, 7);
    prog(5, 12);
    trace_free(1, 1, "R2");

    // R4 zero write while acknowledged ignored
    ctrl_sh[3] = 1'b1; wr(4'd0, ctrl_sh);
    wait_ack(3, "R2");
    wr(4'd5, 32'd0); rd(4'd5, d); chk("R4", d, 32'd2);
    trace_free(2, 7, "R2");
    ctrl_sh[3] = 1'b0; wr(4'd0, ctrl_sh);

    // R5 hold-all
    wr(4'd0, ctrl_sh | 32'h40);
    for (int t = 0; t < 40; t++) begin
      rd(4'd1, d);
      if (d[5:0] == 6'h3F) break;
    end
    chk("R5", d, 32'h3F);
    chk("R5", {26'd0, clk_out}, 32'd0);
    repeat (5) @(negedge clk);
    chk("R5", {26'd0, clk_out}, 32'd0);
    wr(4'd0, ctrl_sh);
    repeat (3) @(negedge clk);
    trace_free(5, 12, "R5");

    // R7 warm reset keeps settings, re-parks held output
    prog(3, 5);
    ctrl_sh[3] = 1'b1; ctrl_sh[8] = 1'b1;
    wr(4'd0, ctrl_sh);
    wait_ack(3, "R7");
    warm_rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7", {26'd0, clk_out}, 32'd0);
    warm_rst = 1'b0;
    rd(4'd0, d); chk("R7", d, exp_ctrl(ctrl_sh));
    rd(4'd5, d); chk("R7", d, 32'd5);
    wait_ack(3, "R7");
    trace_free(2, 7, "R7");
    ctrl_sh[3] = 1'b0; ctrl_sh[8] = 1'b0;
    wr(4'd0, ctrl_sh);

    // random reprogramming
    for (int it = 0; it < 24; it++) begin
      int i = int'($urandom % NO);
      int n = 1 + int'($urandom % 12);
      prog(i, n);
    end
    for (int i = 0; i < NO; i++) begin
      rd(4'(2 + i), d); chk("R4", d, 32'(div_sh[i]));
    end

    // R6 cold reset again after changes
    ctrl_sh = 32'h105; wr(4'd0, ctrl_sh);
    cold_rst = 1'b1;
    repeat (2) @(negedge clk);
    cold_rst = 1'b0;
    rd(4'd0, d); chk("R6", d, 32'h200);
    rd(4'd3, d); chk("R6", d, 32'd2);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule